// File: doc/BRIEF.md
# Interleaved Video/Processor Memory Arbiter

This block lets a raster video fetcher and a processor share one synchronous memory port through a fixed time-slot schedule. A free-running two-bit phase counter divides time into windows of four clocks. The first half of each window always belongs to video: the fetch address goes to memory in phase 0, and the returned word is captured at the end of phase 1. The second half belongs to the processor: a pending request is issued to memory in phase 2, and it completes with a one-clock ready pulse in phase 3.

Arbitration does not depend on requests. Video never yields, and the processor gets at most one access per window. A processor request that arrives away from phase 2 is held off with wait states until the next processor slot. This happens even when the video fetch targets an unrelated region of memory. The stall, from 0 to 3 clocks, is reported on a wait-count output so that its alignment penalty can be seen. The video address steps by one word per fetch and reloads from a base input on a frame-start pulse.

Top module: `vidmem_arbiter`

## Requirements
- R1: The phase advances 0,1,2,3,0,… by one every clock after reset. In every phase-0 clock the memory port is enabled, with write enable low and the address equal to the current video fetch address.
- R2: `vid_valid` is high for exactly one clock per window, in phase 2. `vid_data` then holds the memory word at the address fetched in the preceding phase 0.
- R3: After each fetch the video address increases by one, modulo 2^ADDR_W, so it wraps from all-ones to zero.
- R4: A `vid_frame_start` pulse in any clock loads `vid_base` into the video address at that clock's edge, and the reload takes precedence over the increment. A fetch already issued in the same phase-0 clock keeps its old address.
- R5: A processor access reaches memory only in phase 2, with its own address, write enable and write data. A processor request never changes the phase-0 video access.
- R6: Each granted access raises `cpu_ready` for exactly one clock, in phase 3. For a read, `cpu_rdata` carries the addressed word in that clock.
- R7: A request held high continuously gets at most one access per window. The next ready arrives four clocks after the previous one.
- R8: During the ready clock, `cpu_wait` equals the number of clocks the request waited before its grant: (2 − p) mod 4, where p is the phase of its first request clock. A chained request starts in phase 0 and so waits 2. The count is 0 when no request is pending.
- R9: A processor write stores its data, and a later processor read or video fetch of that address returns it.
- R10: While `rst_n` is low the phase is 0, `cpu_ready`, `cpu_wait` and `vid_valid` are 0, and the video address equals `vid_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_wait | output | 2 | Wait clocks of the current request |
| vid_base | input | ADDR_W | Reload value for the fetch address |
| vid_frame_start | input | 1 | Reload pulse |
| vid_valid | output | 1 | Fetched word available |
| vid_data | output | DATA_W | Fetched word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one clock after address |

## Verification
A phase counter that slips or skips shows at once as `vid_valid` outside its four-clock cadence, or as a processor ready in the wrong clock relative to the start of its request. A corrupted fetch-address register shows up at the first phase-0 address on the memory port, and again two clocks later as wrong `vid_data`. A stuck grant or wait counter shows up at the very next ready pulse, through a wrong `cpu_wait`, a doubled ready, or read data that does not match what the bench wrote.

// File: rtl/vidmem_arbiter_pkg.sv
// Package: shared constants and the slot phase encoding for the arbiter.
// Assumes a fixed four-clock window; the encoding is behavioural, since each
// phase value selects who owns the memory port.
package vidmem_arbiter_pkg;
    localparam int SLOTS   = 4;
    localparam int PHASE_W = $clog2(SLOTS);

    typedef enum logic [PHASE_W-1:0] {
        PH_VID_ISSUE = 2'd0,   // video address on the memory port
        PH_VID_TAKE  = 2'd1,   // video data returns, captured at end
        PH_CPU_ISSUE = 2'd2,   // processor address/write on the port
        PH_CPU_DONE  = 2'd3    // processor data returns, ready pulse
    } phase_e;
endpackage

// File: rtl/vma_slot_timer.sv
// Module: free-running window phase counter and slot decodes.
// Assumes: synchronous active-low reset clears the phase to video issue.
module vma_slot_timer
    import vidmem_arbiter_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output phase_e             phase_o,
    output logic               vid_slot_o,
    output logic               vid_take_o,
    output logic               cpu_slot_o,
    output logic               cpu_done_o
);
    phase_e phase_q;

    // Advance the phase by one every clock, wrapping at the window size.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_VID_ISSUE;
        else        phase_q <= phase_e'(phase_q + 1'b1);
    end

    // Decode the phase into one-hot slot strobes.
    always_comb begin
        vid_slot_o = (phase_q == PH_VID_ISSUE);
        vid_take_o = (phase_q == PH_VID_TAKE);
        cpu_slot_o = (phase_q == PH_CPU_ISSUE);
        cpu_done_o = (phase_q == PH_CPU_DONE);
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/vma_video_fetch.sv
// Module: linear video fetch address generator and data capture.
// Assumes: memory read data is valid the clock after the address (take slot).
module vma_video_fetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_slot_i,
    input  logic              vid_take_i,
    input  logic              frame_start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    // Address: reload on reset or frame start, else step after each issue.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start_i) addr_q <= base_i;
        else if (vid_slot_i)         addr_q <= addr_q + 1'b1;
    end

    // Capture the returned word at the end of the take slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= vid_take_i;
            if (vid_take_i) data_q <= mem_rdata_i;
        end
    end

    assign fetch_addr_o = addr_q;
    assign valid_o      = valid_q;
    assign data_o       = data_q;
endmodule

// File: rtl/vma_cpu_port.sv
// Module: processor slot grant, ready pulse and wait-state counter.
// Assumes: request and its qualifiers are held stable until ready.
module vma_cpu_port
    import vidmem_arbiter_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_slot_i,
    input  logic               cpu_done_i,
    input  logic               req_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               grant_o,
    output logic               ready_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [PHASE_W-1:0] wait_o
);
    localparam logic [PHASE_W-1:0] WAIT_MAX = '1;

    logic               granted_q;
    logic [PHASE_W-1:0] wait_q;

    // Grant only in the processor issue slot while a request is pending.
    assign grant_o = cpu_slot_i && req_i;

    // Remember that the slot was used, so ready follows in the done slot.
    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= 1'b0;
        else        granted_q <= grant_o;
    end

    // Count stalled clocks of the pending request; clear when it completes.
    always_ff @(posedge clk) begin
        if (!rst_n || ready_o)                           wait_q <= '0;
        else if (req_i && !cpu_slot_i && wait_q != WAIT_MAX) wait_q <= wait_q + 1'b1;
    end

    // Ready and read data are presented only in the done slot.
    always_comb begin
        ready_o = granted_q && cpu_done_i;
        rdata_o = ready_o ? mem_rdata_i : '0;
    end

    assign wait_o = wait_q;
endmodule

// File: rtl/vma_mem_mux.sv
// Module: steers the single memory port to the slot owner.
// Assumes: the video slot and processor grant are never active together.
module vma_mem_mux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              vid_slot_i,
    input  logic [ADDR_W-1:0] vid_addr_i,
    input  logic              cpu_grant_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_we_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    // Video first, then the granted processor access, else idle.
    always_comb begin
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        if (vid_slot_i) begin
            mem_en_o   = 1'b1;
            mem_addr_o = vid_addr_i;
        end else if (cpu_grant_i) begin
            mem_en_o    = 1'b1;
            mem_we_o    = cpu_we_i;
            mem_addr_o  = cpu_addr_i;
            mem_wdata_o = cpu_wdata_i;
        end
    end
endmodule

// File: rtl/vidmem_arbiter.sv
// Module: top of the time-slot memory arbiter for video and processor.
// Assumes: synchronous memory with one-clock read latency behind mem_*.
module vidmem_arbiter
    import vidmem_arbiter_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_we,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic [PHASE_W-1:0] cpu_wait,
    input  logic [ADDR_W-1:0]  vid_base,
    input  logic               vid_frame_start,
    output logic               vid_valid,
    output logic [DATA_W-1:0]  vid_data,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    phase_e            phase;
    logic              vid_slot, vid_take, cpu_slot, cpu_done, cpu_grant;
    logic [ADDR_W-1:0] vid_addr;

    vma_slot_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .vid_slot_o (vid_slot),
        .vid_take_o (vid_take),
        .cpu_slot_o (cpu_slot),
        .cpu_done_o (cpu_done)
    );

    vma_video_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_video (
        .clk           (clk),
        .rst_n         (rst_n),
        .vid_slot_i    (vid_slot),
        .vid_take_i    (vid_take),
        .frame_start_i (vid_frame_start),
        .base_i        (vid_base),
        .mem_rdata_i   (mem_rdata),
        .fetch_addr_o  (vid_addr),
        .valid_o       (vid_valid),
        .data_o        (vid_data)
    );

    vma_cpu_port #(.DATA_W(DATA_W)) u_cpu (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_slot_i  (cpu_slot),
        .cpu_done_i  (cpu_done),
        .req_i       (cpu_req),
        .mem_rdata_i (mem_rdata),
        .grant_o     (cpu_grant),
        .ready_o     (cpu_ready),
        .rdata_o     (cpu_rdata),
        .wait_o      (cpu_wait)
    );

    vma_mem_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .vid_slot_i  (vid_slot),
        .vid_addr_i  (vid_addr),
        .cpu_grant_i (cpu_grant),
        .cpu_addr_i  (cpu_addr),
        .cpu_we_i    (cpu_we),
        .cpu_wdata_i (cpu_wdata),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata)
    );
endmodule

// File: rtl/vidmem_arbiter_chk.sv
// Module: property checker bound to the arbiter top.
// Assumes: reset is held low for at least one clock at the start.
module vidmem_arbiter_chk
    import vidmem_arbiter_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input phase_e             phase,
    input logic [ADDR_W-1:0]  vid_addr,
    input logic               vid_frame_start,
    input logic               cpu_req,
    input logic               cpu_ready,
    input logic [PHASE_W-1:0] cpu_wait,
    input logic               vid_valid,
    input logic               mem_en,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr
);
    logic armed;

    // Mark the clocks whose previous clock was also out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> phase == phase_e'($past(phase) + 1'b1)); // R1

    AST_VIDEO_OWNS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VID_ISSUE) |-> (mem_en && !mem_we && mem_addr == vid_addr)); // R5

    AST_VALID_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> phase == PH_CPU_ISSUE); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(phase) == PH_VID_ISSUE && !$past(vid_frame_start))
        |-> vid_addr == $past(vid_addr) + 1'b1); // R3

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R6

    AST_READY_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cpu_ready) |-> ($past(phase) == PH_CPU_ISSUE && $past(cpu_req) && $past(mem_en))); // R5

    AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(cpu_req) && !$past(cpu_ready) && !cpu_req) |-> cpu_wait == $past(cpu_wait)); // R8
endmodule

bind vidmem_arbiter vidmem_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase           (phase),
    .vid_addr        (vid_addr),
    .vid_frame_start (vid_frame_start),
    .cpu_req         (cpu_req),
    .cpu_ready       (cpu_ready),
    .cpu_wait        (cpu_wait),
    .vid_valid       (vid_valid),
    .mem_en          (mem_en),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr)
);

// File: tb/vidmem_arbiter_tb.sv
`timescale 1ns/1ps
module vidmem_arbiter_tb;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_we = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic [1:0]    cpu_wait;
    logic [AW-1:0] vid_base = 8'h10;
    logic          vid_frame_start = 1'b0;
    logic          vid_valid;
    logic [DW-1:0] vid_data;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int ph = 0;
    logic [AW-1:0] exp_next, exp_issue;
    logic [DW-1:0] mem    [0:255];
    logic [DW-1:0] shadow [0:255];

    always #2 clk = ~clk;

    vidmem_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    // Synchronous memory model with one-clock read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    function automatic logic [DW-1:0] init_val(input int i);
        return 16'h5A00 ^ DW'(i * 7);
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one clock, track phase and video address, check video side.
    task automatic tick();
        int   old = ph;
        logic fs  = vid_frame_start;
        @(negedge clk);
        ph = (old + 1) % 4;
        if (old == 0) begin
            exp_issue = exp_next;
            exp_next  = exp_next + 1'b1;
        end
        if (fs) exp_next = vid_base;
        if (ph == 2) begin
            chk(vid_valid == 1'b1, "R2 valid in phase 2", vid_valid, 1);
            chk(vid_data == shadow[exp_issue], "R2/R3/R4 video data", vid_data, shadow[exp_issue]);
        end else begin
            chk(vid_valid == 1'b0, "R2 valid off-slot", vid_valid, 0);
        end
        if (ph == 0) begin
            chk(mem_en && !mem_we, "R1 video slot enable", {mem_en, mem_we}, 2'b10);
            chk(mem_addr == exp_next, "R1/R5 video address at phase 0", mem_addr, exp_next);
        end
    endtask

    task automatic align(input int p);
        while (ph != p) tick();
    endtask

    // One processor access; chained = request already high from previous one.
    task automatic cpu_op(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                          input int exp_w, input int chained);
        int n = exp_w + 1 + chained;
        cpu_req = 1'b1; cpu_addr = a; cpu_we = w; cpu_wdata = d;
        for (int k = 1; k <= n; k++) begin
            tick();
            if (k < n) chk(cpu_ready == 1'b0, "R5/R7 no early ready", cpu_ready, 0);
            else       chk(cpu_ready == 1'b1, "R6 ready in phase 3", cpu_ready, 1);
        end
        chk(ph == 3, "R6 ready phase", ph, 3);
        chk(cpu_wait == 2'(exp_w), "R8 wait count", cpu_wait, exp_w);
        if (w) shadow[a] = d;
        else   chk(cpu_rdata == shadow[a], "R6/R9 read data", cpu_rdata, shadow[a]);
    endtask

    task automatic drop();
        cpu_req = 1'b0;
        tick();
        chk(cpu_ready == 1'b0, "R6 single ready", cpu_ready, 0);
        chk(cpu_wait == 2'd0, "R8 wait idle", cpu_wait, 0);
    endtask

    task automatic frame_pulse(input logic [AW-1:0] b, input int p);
        align(p);
        vid_base = b;
        vid_frame_start = 1'b1;
        tick();
        vid_frame_start = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R10 ready in reset", cpu_ready, 0);
        chk(cpu_wait == 2'd0, "R10 wait in reset", cpu_wait, 0);
        chk(vid_valid == 1'b0, "R10 valid in reset", vid_valid, 0);
        chk(mem_addr == vid_base, "R10 video address = base", mem_addr, vid_base);
        rst_n = 1'b1;
        ph = 0;
        exp_next = vid_base;
        exp_issue = vid_base;
        repeat (8) tick();

        // R8 sweep: every arrival phase, reads then writes
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 4; p++) begin
                align(p);
                cpu_op(AW'(8'hC0 + w * 4 + p), w[0], DW'(16'hA500 + p), (6 - p) % 4, 0);
                drop();
            end
        end
        // R9: read back the writes, arriving at shifted phases
        for (int p = 0; p < 4; p++) begin
            align((p + 1) % 4);
            cpu_op(AW'(8'hC4 + p), 1'b0, '0, (6 - (p + 1) % 4) % 4, 0);
            drop();
        end
        // R7: held request gets one access per window
        align(2);
        cpu_op(8'hD0, 1'b0, '0, 0, 0);
        cpu_op(8'hD1, 1'b1, 16'h1234, 2, 1);
        cpu_op(8'hD1, 1'b0, '0, 2, 1);
        drop();
        // R9: video sees a processor write
        align(2);
        cpu_op(8'h30, 1'b1, 16'hBEEF, 0, 0);
        drop();
        // R4: reload at phase 3 and at phase 0
        frame_pulse(8'h2E, 3);
        repeat (10) tick();
        frame_pulse(8'h40, 0);
        repeat (10) tick();
        // R3: wrap of the fetch address, with processor traffic
        frame_pulse(8'hFE, 1);
        align(3);
        cpu_op(8'h01, 1'b1, 16'h0F0F, 3, 0);
        drop();
        repeat (24) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule